// File: doc/BRIEF.md
# Single-Bit Sector ECC Corrector

This block checks the 24-bit check code kept with a 512-byte flash sector against the code recomputed when the sector is read back. The two codes are XORed into a syndrome, and the syndrome is sorted into one of four outcomes:
- clean data;
- one flipped data bit, which can be located and repaired;
- one flipped bit in the stored code itself, which leaves the data untouched;
- damage that cannot be repaired.

For a repairable error the block reports which byte of the sector and which bit of that byte are wrong. It also offers a read-modify-write path: the sector buffer presents the byte at the reported index, and the block returns it with the bad bit inverted.

The block is used once per sector. The reader loads both codes, pulses `start_i`, and one clock later receives `done_o` together with the registered verdict. The verdict stays in place until the next start, so the buffer can fetch the faulty byte, pass it through the block and write it back. Code generation and sector storage sit outside this block.

Top module: `ecc_corrector`

## Requirements
- R1: `done_o` is high for exactly the cycle after each cycle in which `start_i` was sampled high, and is low otherwise.
- R2: A syndrome (`stored_code_i ^ calc_code_i`) of zero gives `status_o` = 0 (clean).
- R3: A syndrome in which each of the 12 bit pairs (2k, 2k+1) has exactly one bit set gives `status_o` = 1 (data bit corrected).
- R4: With status 1, `bit_idx_o` = {syn[23], syn[21], syn[19]}, listed MSB first.
- R5: With status 1, `byte_idx_o` = {syn[17], syn[7], syn[5], syn[3], syn[1], syn[15], syn[13], syn[11], syn[9]}, listed MSB first.
- R6: A syndrome with exactly one bit set gives `status_o` = 2 (stored code corrupt, data intact).
- R7: Any other non-zero syndrome gives `status_o` = 3 (uncorrectable).
- R8: When `status_o` is not 1, `byte_idx_o` and `bit_idx_o` are both zero.
- R9: `rmw_byte_o` equals `rmw_byte_i` with bit `bit_idx_o` inverted when `status_o` is 1. Otherwise it equals `rmw_byte_i` unchanged. The path is combinational.
- R10: After reset all outputs are zero. `status_o` and both indices hold their values until the next start, whatever the code inputs do in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Sample the codes and evaluate |
| stored_code_i | input | 24 | Code read from the flash spare area |
| calc_code_i | input | 24 | Code recomputed over the read data |
| rmw_byte_i | input | 8 | Sector byte presented for repair |
| done_o | output | 1 | Result valid pulse |
| status_o | output | 2 | 0 clean, 1 corrected, 2 code error, 3 uncorrectable |
| byte_idx_o | output | 9 | Index of the faulty byte |
| bit_idx_o | output | 3 | Index of the faulty bit within the byte |
| rmw_byte_o | output | 8 | Repaired byte |

## Verification
The hardest outcomes to reach from the ports are the extreme repairable syndromes (all even bits set, or all odd bits set) and the near-miss patterns: every pair but one is correct, and the remaining pair has both bits set or neither. Random code pairs almost never land on these. The bench therefore builds each syndrome directly from a chosen byte and bit index, or from a chosen set of damaged pairs. It XORs that syndrome onto an arbitrary stored code, so the boundary indices 0 and 511 and each near-miss shape are produced on purpose.

// File: rtl/ecc_corr_pkg.sv
package ecc_corr_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN = 2'd0,
    ST_FIXED = 2'd1,
    ST_CODE  = 2'd2,
    ST_FATAL = 2'd3
  } ecc_status_e;

  // syndrome bit feeding byte index bit i (LSB first)
  function automatic int byte_src(input int i);
    case (i)
      0: return 9;
      1: return 11;
      2: return 13;
      3: return 15;
      4: return 1;
      5: return 3;
      6: return 5;
      7: return 7;
      default: return 17;
    endcase
  endfunction

  // syndrome bit feeding bit index bit i (LSB first)
  function automatic int bit_src(input int i);
    case (i)
      0: return 19;
      1: return 21;
      default: return 23;
    endcase
  endfunction
endpackage

// File: rtl/ecc_classify.sv
module ecc_classify
  import ecc_corr_pkg::*;
#(
  parameter int CODE_W = 24
) (
  input  logic [CODE_W-1:0] syn_i,
  output ecc_status_e       status_o
);
  localparam int NPAIR = CODE_W / 2;

  logic [NPAIR-1:0] pair_ok;

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    assign pair_ok[k] = syn_i[2*k] ^ syn_i[2*k+1];
  end

  always_comb begin
    if (syn_i == '0)         status_o = ST_CLEAN;
    else if (&pair_ok)       status_o = ST_FIXED;
    else if ($onehot(syn_i)) status_o = ST_CODE;
    else                     status_o = ST_FATAL;
  end
endmodule

// File: rtl/ecc_locate.sv
module ecc_locate
  import ecc_corr_pkg::*;
#(
  parameter int CODE_W = 24,
  parameter int BYTE_W = 9,
  parameter int BIT_W  = 3
) (
  input  logic [CODE_W-1:0] syn_i,
  output logic [BYTE_W-1:0] byte_idx_o,
  output logic [BIT_W-1:0]  bit_idx_o
);
  for (genvar i = 0; i < BYTE_W; i++) begin : g_byte
    assign byte_idx_o[i] = syn_i[byte_src(i)];
  end

  for (genvar i = 0; i < BIT_W; i++) begin : g_bit
    assign bit_idx_o[i] = syn_i[bit_src(i)];
  end
endmodule

// File: rtl/ecc_bit_flip.sv
module ecc_bit_flip #(
  parameter int DATA_W = 8,
  parameter int BIT_W  = 3
) (
  input  logic              en_i,
  input  logic [BIT_W-1:0]  bit_idx_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] mask;

  assign mask   = en_i ? (ONE << bit_idx_i) : '0;
  assign data_o = data_i ^ mask;
endmodule

// File: rtl/ecc_corrector.sv
module ecc_corrector
  import ecc_corr_pkg::*;
#(
  parameter int CODE_W = 24,
  parameter int BYTE_W = 9,
  parameter int BIT_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CODE_W-1:0] stored_code_i,
  input  logic [CODE_W-1:0] calc_code_i,
  input  logic [DATA_W-1:0] rmw_byte_i,
  output logic              done_o,
  output logic [1:0]        status_o,
  output logic [BYTE_W-1:0] byte_idx_o,
  output logic [BIT_W-1:0]  bit_idx_o,
  output logic [DATA_W-1:0] rmw_byte_o
);
  logic [CODE_W-1:0] syn;
  ecc_status_e       st_d, st_q;
  logic [BYTE_W-1:0] byte_d, byte_q;
  logic [BIT_W-1:0]  bit_d, bit_q;
  logic              done_q;

  assign syn = stored_code_i ^ calc_code_i;

  ecc_classify #(.CODE_W(CODE_W)) u_cls (
    .syn_i    (syn),
    .status_o (st_d)
  );

  ecc_locate #(.CODE_W(CODE_W), .BYTE_W(BYTE_W), .BIT_W(BIT_W)) u_loc (
    .syn_i      (syn),
    .byte_idx_o (byte_d),
    .bit_idx_o  (bit_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_CLEAN;
      byte_q <= '0;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= start_i;
      if (start_i) begin
        st_q <= st_d;
        // indices are meaningful only for a repairable error
        byte_q <= (st_d == ST_FIXED) ? byte_d : '0;
        bit_q  <= (st_d == ST_FIXED) ? bit_d  : '0;
      end
    end
  end

  ecc_bit_flip #(.DATA_W(DATA_W), .BIT_W(BIT_W)) u_fix (
    .en_i      (st_q == ST_FIXED),
    .bit_idx_i (bit_q),
    .data_i    (rmw_byte_i),
    .data_o    (rmw_byte_o)
  );

  assign done_o     = done_q;
  assign status_o   = st_q;
  assign byte_idx_o = byte_q;
  assign bit_idx_o  = bit_q;

  // R1
  done_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);
  // R1
  done_only_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);
  // R10
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(status_o) && $stable(byte_idx_o) && $stable(bit_idx_o)));
  // R8
  idx_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o != ST_FIXED) |-> (byte_idx_o == '0 && bit_idx_o == '0));
  // R9
  rmw_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o != ST_FIXED) |-> (rmw_byte_o == rmw_byte_i));
  // R9
  rmw_one_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == ST_FIXED) |-> ($countones(rmw_byte_o ^ rmw_byte_i) == 1));
  // R2
  clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && stored_code_i == calc_code_i) |=> (status_o == ST_CLEAN));
  // R6
  code_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && $onehot(syn)) |=> (status_o == ST_CODE));
endmodule

// File: tb/sim_ecc_corrector.sv
`timescale 1ns/1ps
module sim_ecc_corrector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] stored = '0, calc = '0;
  logic [7:0]  rmw_in = '0;
  logic        done;
  logic [1:0]  status;
  logic [8:0]  byte_idx;
  logic [2:0]  bit_idx;
  logic [7:0]  rmw_out;

  int tests = 0, fails = 0;
  bit finished = 0;

  // reference state
  int e_done = 0, e_status = 0, e_byte = 0, e_bit = 0;

  always #2.5 clk = ~clk;

  ecc_corrector u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .stored_code_i(stored), .calc_code_i(calc), .rmw_byte_i(rmw_in),
    .done_o(done), .status_o(status), .byte_idx_o(byte_idx),
    .bit_idx_o(bit_idx), .rmw_byte_o(rmw_out)
  );

  // index bit -> syndrome position, LSB first
  int bpos[9] = '{9, 11, 13, 15, 1, 3, 5, 7, 17};
  int tpos[3] = '{19, 21, 23};

  task automatic model_eval(input logic [23:0] s);
    int pairs_ok = 0, ones = 0;
    for (int k = 0; k < 12; k++) if (s[2*k] != s[2*k+1]) pairs_ok++;
    for (int k = 0; k < 24; k++) if (s[k]) ones++;
    e_byte = 0; e_bit = 0;
    if (s == 0) e_status = 0;
    else if (pairs_ok == 12) begin
      e_status = 1;
      for (int i = 0; i < 9; i++) if (s[bpos[i]]) e_byte += (1 << i);
      for (int i = 0; i < 3; i++) if (s[tpos[i]]) e_bit += (1 << i);
    end else if (ones == 1) e_status = 2;
    else e_status = 3;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_done = 0; e_status = 0; e_byte = 0; e_bit = 0;
    end else begin
      e_done = start ? 1 : 0;
      if (start) model_eval(stored ^ calc);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle away from the edge
  always @(negedge clk) begin
    if (!finished) begin
      int exp_rmw;
      string st_tag;
      exp_rmw = int'(rmw_in);
      if (e_status == 1) exp_rmw = exp_rmw ^ (1 << e_bit);
      case (e_status)
        0: st_tag = "R2 status";
        1: st_tag = "R3 status";
        2: st_tag = "R6 status";
        default: st_tag = "R7 status";
      endcase
      chk(rst_n ? "R1 done" : "R10 reset done", int'(done), e_done);
      chk(rst_n ? st_tag : "R10 reset status", int'(status), e_status);
      chk(e_status == 1 ? "R5 byte_idx" : "R8 byte_idx", int'(byte_idx), e_byte);
      chk(e_status == 1 ? "R4 bit_idx" : "R8 bit_idx", int'(bit_idx), e_bit);
      chk("R9 rmw", int'(rmw_out), exp_rmw);
    end
  end

  function automatic logic [23:0] make_syn(input int b, input int t);
    logic [23:0] s = '0;
    for (int i = 0; i < 9; i++) begin
      if ((b >> i) & 1) s[bpos[i]] = 1'b1; else s[bpos[i]-1] = 1'b1;
    end
    for (int i = 0; i < 3; i++) begin
      if ((t >> i) & 1) s[tpos[i]] = 1'b1; else s[tpos[i]-1] = 1'b1;
    end
    return s;
  endfunction

  task automatic run(input logic [23:0] st, input logic [23:0] syn, input logic [7:0] b);
    @(negedge clk); #1;
    stored = st; calc = st ^ syn; rmw_in = b; start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    @(negedge clk); #1;
    rmw_in = ~b;
    @(negedge clk);
  endtask

  initial begin
    logic [23:0] lf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run(24'h3C96A5, 24'h0, 8'h5A);                      // R2
    run(24'h123456, make_syn(0, 0), 8'h00);             // R3 R4 R5 low corner
    run(24'hFEDCBA, make_syn(511, 7), 8'hFF);           // R3 R4 R5 high corner
    run(24'h000000, 24'h555555, 8'h81);                 // R5 byte 0 bit 0
    run(24'hABCDEF, 24'hAAAAAA, 8'h18);                 // R5 byte 511 bit 7
    run(24'h0F0F0F, 24'h000001, 8'hC3);                 // R6
    run(24'h0F0F0F, 24'h800000, 8'hC3);                 // R6
    run(24'h111111, 24'h000003, 8'h77);                 // R7 pair both set
    run(24'h111111, make_syn(77, 3) ^ 24'h000001, 8'h77); // R7 one pair empty
    run(24'h111111, make_syn(200, 5) | 24'h000003, 8'h77); // R7 one pair full
    run(24'h222222, 24'hFFFFFF, 8'h3E);                 // R7
    lf = 24'hACE1F3;
    for (int n = 0; n < 40; n++) begin
      lf = {lf[22:0], lf[23] ^ lf[22] ^ lf[21] ^ lf[16]};
      run(lf, make_syn(int'(lf[8:0]), int'(lf[14:12])), lf[7:0]);
    end
    for (int n = 0; n < 20; n++) begin
      lf = {lf[22:0], lf[23] ^ lf[22] ^ lf[21] ^ lf[16]};
      run(lf, lf ^ {lf[11:0], lf[23:12]}, lf[15:8]);
    end
    // R10 hold: codes change without start, result must not move
    run(24'h0, make_syn(300, 6), 8'h42);
    for (int n = 0; n < 5; n++) begin
      @(negedge clk); #1;
      stored = 24'hFFFFFF; calc = 24'h000001 << n; rmw_in = 8'(n * 37);
    end
    @(negedge clk);
    chk("R10 hold status", int'(status), 1);
    chk("R10 hold byte", int'(byte_idx), 300);
    // R1 back-to-back starts
    @(negedge clk); #1;
    stored = 24'h0; calc = 24'h000010; start = 1'b1;
    @(negedge clk); #1;
    calc = 24'h0;
    @(negedge clk); #1;
    start = 1'b0;
    repeat (3) @(negedge clk);
    // R10 async reset mid-result
    run(24'h0, make_syn(5, 2), 8'h00);
    #1 rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule